// File: doc/BRIEF.md
# Clock-Output Power-Down and Mode Controller

This block is the digital control of a multi-output clock generator. The outputs fall into six groups: CPU, memory reference, 66 MHz, 33 MHz PCI, 48 MHz and reference. The crystal oscillator, the PLLs and the spread modulator sit outside the block. The block drives an enable for each of them and receives one source clock per group. It gates each group clock and makes sure a group can only stop after a complete high phase. Each output then rests at a low level.

An asynchronous active-low power-down request enters through a synchronizer on the always-on control clock `clk`. When the request is seen, every group gate closes on a falling edge of that group's own clock. Each group reports back once it has stopped. Only after all groups have reported does the block drop the oscillator and PLL enables together. Wake-up runs in the reverse order: oscillator enable, then PLL enable one cycle later, then a programmable settle count, then the gates reopen.

A 3-bit mode code selects one of four modes: 100 MHz CPU, 133 MHz CPU, all-outputs high impedance, or test. In test mode every group takes its clock from an external test clock divided by a fixed per-group ratio. An active-low spread control enables spreading for the four lower groups only.

Top module: `clkgen_pwr_ctrl`

## Requirements
- R1: `pdN` passes through a two-flop synchronizer on `clk`. When `pdN` changes just after a rising edge of `clk`, `oscEn` responds after exactly three rising edges.
- R2: Each `grpClkOut` bit starts and stops only at full high phases of its source clock. Every high pulse lasts exactly one high phase of the source, so no runt pulse appears when a group is gated on or off.
- R3: `outsQuiet` is 0 while the outputs run. It is 1 whenever `oscEn` is 0. No output pulse occurs while the block is powered down.
- R4: `oscEn` and `pllEn` fall in the same cycle, only when `outsQuiet` was already 1 in the cycle before. All `grpClkOut` bits are 0 whenever `oscEn` is 0.
- R5: On wake-up `oscEn` rises first and `pllEn` rises exactly one `clk` cycle later. `pllEn` is never 1 while `oscEn` is 0.
- R6: The first output pulse after wake-up comes at least `settleCycles`+1 and at most `settleCycles`+20 `clk` cycles after `pllEn` rises. This includes `settleCycles` = 0.
- R7: `modeSel` = {speed select, FS1, FS0} is registered in one `clk` cycle. Code 000 clears `cpuFast`, 100 sets `cpuFast`, 011 sets `outsHiZ`, and 111 sets `testMode`. Only the flag that matches the code is set.
- R8: The reserved codes 001, 010, 101 and 110 leave `cpuFast`, `outsHiZ` and `testMode` unchanged and set `modeErr` one cycle later. A valid code clears `modeErr`.
- R9: In test mode, group g (0 CPU, 1 memory reference, 2 66 MHz, 3 PCI, 4 48 MHz, 5 reference) runs from `testClk` divided by 2, 4, 1, 6, 1 and 1 respectively. The mode is changed only while the outputs are stopped.
- R10: `spreadEn` is 6'b001111 one cycle after `spreadN` is low and 0 one cycle after it is high. Bits 5:4 are never set.
- R11: During and right after reset: `oscEn` = 0, `pllEn` = 0, `outsQuiet` = 1, all outputs are 0, the mode is 000, and `modeErr` = 0. The block stays down while `pdN` is low.
- R12: A power-down request that arrives during wake-up, before the gates reopen, returns the block to the down state with no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdN | input | 1 | Asynchronous active-low power-down request |
| spreadN | input | 1 | Active-low spread enable |
| modeSel | input | 3 | Mode code {speed select, FS1, FS0} |
| settleCycles | input | CNT_W | Settle count loaded at PLL enable |
| testClk | input | 1 | External test clock |
| grpClkIn | input | NUM_GRP | Per-group source clocks from the PLLs |
| grpClkOut | output | NUM_GRP | Gated group clocks |
| spreadEn | output | NUM_GRP | Per-group spread enable |
| cpuFast | output | 1 | 133 MHz CPU setting selected |
| outsHiZ | output | 1 | All outputs to high impedance |
| testMode | output | 1 | Test-clock sourcing selected |
| modeErr | output | 1 | Last mode code was reserved |
| oscEn | output | 1 | Crystal oscillator enable |
| pllEn | output | 1 | PLL enable |
| outsQuiet | output | 1 | All groups confirmed stopped low |

## Verification
If the sequencer state is wrong, the oscillator or PLL enable moves in the wrong cycle. That shows within one `clk` cycle as a drop without a prior `outsQuiet`, a PLL enable ahead of the oscillator enable, or an output pulse while the enables are low. If a gate enable is sampled on the wrong edge, a shortened high pulse appears at the first start or stop of that group, and the pulse-width monitor reports it at that pulse. If the mode register takes a reserved code or decodes a code wrongly, the flags differ from the per-cycle model on the next clock.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;

  typedef enum logic [2:0] {
    PS_DOWN, PS_OSC, PS_PLL, PS_SETTLE, PS_RUN, PS_DRAIN
  } pwrState_t;

  // strobes from the sequencer to the group datapath
  typedef struct packed {
    logic gateOpen;
    logic testSel;
  } grpStrobe_t;

  localparam logic [2:0] MODE_CPU100 = 3'b000;
  localparam logic [2:0] MODE_CPU133 = 3'b100;
  localparam logic [2:0] MODE_HIZ    = 3'b011;
  localparam logic [2:0] MODE_TEST   = 3'b111;

  function automatic logic modeValid(input logic [2:0] code);
    return (code == MODE_CPU100) || (code == MODE_CPU133) ||
           (code == MODE_HIZ) || (code == MODE_TEST);
  endfunction

endpackage

// File: rtl/cg_ctrl.sv
`timescale 1ns/1ps
module cg_ctrl
  import cg_pkg::*;
#(
  parameter int NUM_GRP = 6,
  parameter int CNT_W = 16,
  parameter logic [NUM_GRP-1:0] SPREAD_MASK = 6'b001111
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pdN,
  input  logic               spreadN,
  input  logic [2:0]         modeSel,
  input  logic [CNT_W-1:0]   settleCycles,
  input  logic [NUM_GRP-1:0] grpAck,
  output grpStrobe_t         strobe,
  output logic [NUM_GRP-1:0] spreadEn,
  output logic               cpuFast,
  output logic               outsHiZ,
  output logic               testMode,
  output logic               modeErr,
  output logic               oscEn,
  output logic               pllEn,
  output logic               outsQuiet
);

  logic [1:0] pdMeta;
  logic pdReq;
  pwrState_t state, stateNxt;
  logic [CNT_W-1:0] settleCnt;
  logic [2:0] modeReg;
  logic allOff, allOn;

  // two-flop synchronizer; reset value means "power-down requested"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdMeta <= 2'b11;
    else       pdMeta <= {pdMeta[0], ~pdN};
  end
  assign pdReq = pdMeta[1];

  assign allOff = &grpAck;
  assign allOn  = ~|grpAck;

  always_comb begin
    stateNxt = state;
    unique case (state)
      PS_DOWN:   if (!pdReq) stateNxt = PS_OSC;
      PS_OSC:    stateNxt = pdReq ? PS_DRAIN : PS_PLL;
      PS_PLL:    stateNxt = pdReq ? PS_DRAIN : PS_SETTLE;
      PS_SETTLE: if (pdReq) stateNxt = PS_DRAIN;
                 else if (settleCnt == '0) stateNxt = PS_RUN;
      PS_RUN:    if (pdReq && allOn) stateNxt = PS_DRAIN;
      PS_DRAIN:  if (allOff) stateNxt = PS_DOWN;
      default:   stateNxt = PS_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_DOWN;
    else       state <= stateNxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) settleCnt <= '0;
    else if (state == PS_PLL) settleCnt <= settleCycles;
    else if (state == PS_SETTLE && settleCnt != '0) settleCnt <= settleCnt - 1'b1;
  end

  assign oscEn = (state != PS_DOWN);
  assign pllEn = (state != PS_DOWN) && (state != PS_OSC);
  assign outsQuiet = allOff;

  // mode register: reserved codes keep the previous mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_CPU100;
      modeErr <= 1'b0;
    end else if (modeValid(modeSel)) begin
      modeReg <= modeSel;
      modeErr <= 1'b0;
    end else begin
      modeErr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) spreadEn <= '0;
    else       spreadEn <= spreadN ? '0 : SPREAD_MASK;
  end

  assign cpuFast  = (modeReg == MODE_CPU133);
  assign outsHiZ  = (modeReg == MODE_HIZ);
  assign testMode = (modeReg == MODE_TEST);

  assign strobe.gateOpen = (state == PS_RUN);
  assign strobe.testSel  = testMode;

endmodule

// File: rtl/cg_grp_path.sv
`timescale 1ns/1ps
module cg_grp_path
  import cg_pkg::*;
#(
  parameter int NUM_GRP = 6,
  parameter logic [NUM_GRP*4-1:0] TEST_DIV = {4'd1, 4'd1, 4'd6, 4'd1, 4'd4, 4'd2}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               testClk,
  input  logic [NUM_GRP-1:0] grpClkIn,
  input  grpStrobe_t         strobe,
  output logic [NUM_GRP-1:0] grpClkOut,
  output logic [NUM_GRP-1:0] grpAck
);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int DIV_G = int'(TEST_DIV[g*4 +: 4]);
    logic testSrc, srcClk, enLow;
    logic [1:0] gateMeta, ackMeta;

    if (DIV_G > 1) begin : g_div
      // even ratio, 50% duty: toggle every DIV_G/2 test clocks
      logic [3:0] divCnt;
      logic divClk;
      always_ff @(posedge testClk or negedge rstN) begin
        if (!rstN) begin
          divCnt <= '0;
          divClk <= 1'b0;
        end else if (divCnt == 4'(DIV_G/2 - 1)) begin
          divCnt <= '0;
          divClk <= ~divClk;
        end else begin
          divCnt <= divCnt + 4'd1;
        end
      end
      assign testSrc = divClk;
    end else begin : g_thru
      assign testSrc = testClk;
    end

    // source select is static while the gate is closed
    assign srcClk = strobe.testSel ? testSrc : grpClkIn[g];

    always_ff @(posedge srcClk or negedge rstN) begin
      if (!rstN) gateMeta <= 2'b00;
      else       gateMeta <= {gateMeta[0], strobe.gateOpen};
    end

    // enable moves only while the source is low: no runt pulse
    always_ff @(negedge srcClk or negedge rstN) begin
      if (!rstN) enLow <= 1'b0;
      else       enLow <= gateMeta[1];
    end

    assign grpClkOut[g] = srcClk & enLow;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ackMeta <= 2'b11;
      else       ackMeta <= {ackMeta[0], ~enLow};
    end
    assign grpAck[g] = ackMeta[1];
  end

endmodule

// File: rtl/clkgen_pwr_ctrl.sv
`timescale 1ns/1ps
module clkgen_pwr_ctrl
  import cg_pkg::*;
#(
  parameter int NUM_GRP = 6,
  parameter int CNT_W = 16,
  parameter logic [NUM_GRP-1:0] SPREAD_MASK = 6'b001111,
  parameter logic [NUM_GRP*4-1:0] TEST_DIV = {4'd1, 4'd1, 4'd6, 4'd1, 4'd4, 4'd2}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pdN,
  input  logic               spreadN,
  input  logic [2:0]         modeSel,
  input  logic [CNT_W-1:0]   settleCycles,
  input  logic               testClk,
  input  logic [NUM_GRP-1:0] grpClkIn,
  output logic [NUM_GRP-1:0] grpClkOut,
  output logic [NUM_GRP-1:0] spreadEn,
  output logic               cpuFast,
  output logic               outsHiZ,
  output logic               testMode,
  output logic               modeErr,
  output logic               oscEn,
  output logic               pllEn,
  output logic               outsQuiet
);

  grpStrobe_t strobe;
  logic [NUM_GRP-1:0] grpAck;

  cg_ctrl #(
    .NUM_GRP(NUM_GRP), .CNT_W(CNT_W), .SPREAD_MASK(SPREAD_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pdN(pdN), .spreadN(spreadN),
    .modeSel(modeSel), .settleCycles(settleCycles), .grpAck(grpAck),
    .strobe(strobe), .spreadEn(spreadEn), .cpuFast(cpuFast),
    .outsHiZ(outsHiZ), .testMode(testMode), .modeErr(modeErr),
    .oscEn(oscEn), .pllEn(pllEn), .outsQuiet(outsQuiet)
  );

  cg_grp_path #(
    .NUM_GRP(NUM_GRP), .TEST_DIV(TEST_DIV)
  ) u_path (
    .clk(clk), .rstN(rstN), .testClk(testClk), .grpClkIn(grpClkIn),
    .strobe(strobe), .grpClkOut(grpClkOut), .grpAck(grpAck)
  );

endmodule

// File: rtl/cg_checker.sv
`timescale 1ns/1ps
module cg_checker #(
  parameter int NUM_GRP = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               oscEn,
  input logic               pllEn,
  input logic               outsQuiet,
  input logic               modeErr,
  input logic               cpuFast,
  input logic               outsHiZ,
  input logic               testMode,
  input logic [NUM_GRP-1:0] grpClkOut
);

  AST_OSC_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oscEn) |-> $past(outsQuiet)); // R4

  AST_OFF_OUTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (grpClkOut == '0)); // R4

  AST_PLL_AFTER_OSC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllEn) |-> $past(oscEn)); // R5

  AST_PLL_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rstN)
    pllEn |-> oscEn); // R5

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> outsQuiet); // R3

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> $stable({cpuFast, outsHiZ, testMode})); // R8

endmodule

bind clkgen_pwr_ctrl cg_checker #(.NUM_GRP(NUM_GRP)) u_cg_checker (
  .clk(clk), .rstN(rstN), .oscEn(oscEn), .pllEn(pllEn),
  .outsQuiet(outsQuiet), .modeErr(modeErr), .cpuFast(cpuFast),
  .outsHiZ(outsHiZ), .testMode(testMode), .grpClkOut(grpClkOut)
);

// File: tb/clkgen_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module clkgen_pwr_ctrl_bench;

  logic clk = 1'b0, rstN = 1'b0, pdN = 1'b0, spreadN = 1'b1, testClk = 1'b0;
  logic [2:0] modeSel = 3'b000;
  logic [15:0] settle = 16'd5;
  wire [5:0] grpClkIn, grpClkOut, spreadEn;
  wire cpuFast, outsHiZ, testMode, modeErr, oscEn, pllEn, outsQuiet;

  int checks = 0, errors = 0, cyc = 0, totalPulses = 0;
  int pulseCnt [6];
  int snap [6];
  bit started = 0;

  always #5 clk = ~clk;
  always #2 testClk = ~testClk;

  clkgen_pwr_ctrl u_clkgen_pwr_ctrl (
    .clk(clk), .rstN(rstN), .pdN(pdN), .spreadN(spreadN), .modeSel(modeSel),
    .settleCycles(settle), .testClk(testClk), .grpClkIn(grpClkIn),
    .grpClkOut(grpClkOut), .spreadEn(spreadEn), .cpuFast(cpuFast),
    .outsHiZ(outsHiZ), .testMode(testMode), .modeErr(modeErr),
    .oscEn(oscEn), .pllEn(pllEn), .outsQuiet(outsQuiet)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int halfOf(input int g);
    case (g)
      0: return 3; 1: return 5; 2: return 4; 3: return 6; 4: return 7;
      default: return 9;
    endcase
  endfunction

  function automatic int divOf(input int g);
    case (g)
      0: return 2; 1: return 4; 3: return 6;
      default: return 1;
    endcase
  endfunction

  // behavioural reference of the registered mode and spread outputs
  logic [2:0] expMode = 3'b000;
  logic expErr = 1'b0;
  logic [5:0] expSpread = 6'b0;
  wire expTest = (expMode == 3'b111);

  always @(posedge clk) begin
    if (!rstN) begin
      expMode <= 3'b000; expErr <= 1'b0; expSpread <= 6'b0;
    end else begin
      if (modeSel == 3'b000 || modeSel == 3'b100 || modeSel == 3'b011 || modeSel == 3'b111) begin
        expMode <= modeSel; expErr <= 1'b0;
      end else begin
        expErr <= 1'b1;
      end
      expSpread <= spreadN ? 6'b000000 : 6'b001111;
    end
  end

  // PLL model: group sources run only while pllEn is high
  for (genvar g = 0; g < 6; g++) begin : g_src
    logic c = 1'b0;
    initial forever begin
      #(halfOf(g));
      if (pllEn) c = ~c; else c = 1'b0;
    end
    assign grpClkIn[g] = c;
  end

  // pulse-width monitor per group: R2 normal sources, R9 test-clock sources
  for (genvar g = 0; g < 6; g++) begin : g_mon
    realtime tRise = 0;
    always @(posedge grpClkOut[g]) begin
      tRise = $realtime;
      pulseCnt[g]++;
    end
    always @(negedge grpClkOut[g]) begin
      realtime d;
      real e;
      d = $realtime - tRise;
      e = expTest ? 2.0 * divOf(g) : 1.0 * halfOf(g);
      chk(d > e - 0.01 && d < e + 0.01, expTest ? "R9" : "R2",
          $sformatf("group %0d high time (ps)", g), int'(d * 1000), int'(e * 1000));
    end
  end

  bit prevOsc = 0, prevPll = 0, prevQuiet = 1, waitFirst = 0;
  int oscRiseCyc = -100, pllRiseCyc = 0;
  wire anyOut = |grpClkOut;

  always @(posedge anyOut) begin
    totalPulses++;
    if (waitFirst) begin
      chk(cyc - pllRiseCyc >= int'(settle) + 1 && cyc - pllRiseCyc <= int'(settle) + 20,
          "R6", "cycles from pllEn to first pulse", cyc - pllRiseCyc, int'(settle) + 1);
      waitFirst = 0;
    end
  end

  // per-cycle comparison, sampled on the falling edge of clk
  always @(negedge clk) begin
    cyc++;
    if (started) begin
      chk(cpuFast == (expMode == 3'b100), "R7", "cpuFast", cpuFast, expMode == 3'b100);
      chk(outsHiZ == (expMode == 3'b011), "R7", "outsHiZ", outsHiZ, expMode == 3'b011);
      chk(testMode == expTest, "R7", "testMode", testMode, expTest);
      chk(modeErr == expErr, "R8", "modeErr", modeErr, expErr);
      chk(spreadEn == expSpread, "R10", "spreadEn", spreadEn, expSpread);
      if (!oscEn) begin
        chk(grpClkOut == 6'b0, "R4", "outputs while osc off", grpClkOut, 0);
        chk(outsQuiet, "R3", "quiet while osc off", outsQuiet, 1);
      end
      if (pllEn) chk(oscEn, "R5", "osc with pll", oscEn, 1);
      if (prevOsc && !oscEn) begin
        chk(prevQuiet, "R4", "quiet before osc drop", prevQuiet, 1);
        chk(!pllEn, "R4", "pll drops with osc", pllEn, 0);
      end
      if (!prevOsc && oscEn) oscRiseCyc = cyc;
      if (!prevPll && pllEn) begin
        chk(cyc - oscRiseCyc == 1, "R5", "pll after osc cycles", cyc - oscRiseCyc, 1);
        pllRiseCyc = cyc;
        waitFirst = 1;
      end
    end
    prevOsc = oscEn;
    prevPll = pllEn;
    prevQuiet = outsQuiet;
  end

  task automatic waitOscLevel(input bit lvl, input string req);
    int n = 0;
    while (oscEn != lvl && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(oscEn == lvl, req, "oscEn level reached", oscEn, lvl);
  endtask

  task automatic takeSnap();
    for (int g = 0; g < 6; g++) snap[g] = pulseCnt[g];
  endtask

  task automatic checkRunning(input string req);
    for (int g = 0; g < 6; g++)
      chk(pulseCnt[g] > snap[g], req, $sformatf("group %0d pulses", g), pulseCnt[g], snap[g] + 1);
  endtask

  initial begin
    int base;
    for (int g = 0; g < 6; g++) pulseCnt[g] = 0;
    repeat (3) @(negedge clk);
    chk(!oscEn, "R11", "oscEn in reset", oscEn, 0);
    chk(!pllEn, "R11", "pllEn in reset", pllEn, 0);
    chk(outsQuiet, "R11", "quiet in reset", outsQuiet, 1);
    chk(grpClkOut == 6'b0, "R11", "outputs in reset", grpClkOut, 0);
    chk(!cpuFast && !modeErr, "R11", "mode in reset", {cpuFast, modeErr}, 0);
    rstN = 1'b1;
    started = 1;
    repeat (4) @(negedge clk);
    chk(!oscEn, "R11", "stays down while pdN low", oscEn, 0);

    // R1: exact synchronizer latency
    pdN = 1'b1;
    @(negedge clk); chk(!oscEn, "R1", "oscEn after 1 edge", oscEn, 0);
    @(negedge clk); chk(!oscEn, "R1", "oscEn after 2 edges", oscEn, 0);
    @(negedge clk); chk(oscEn, "R1", "oscEn after 3 edges", oscEn, 1);
    takeSnap();
    repeat (60) @(negedge clk);
    checkRunning("R2");
    chk(!outsQuiet, "R3", "quiet while running", outsQuiet, 0);

    // R7 / R8: mode codes while running (flags only)
    modeSel = 3'b100; repeat (3) @(negedge clk);
    chk(cpuFast, "R7", "133 setting", cpuFast, 1);
    modeSel = 3'b011; repeat (3) @(negedge clk);
    chk(outsHiZ, "R7", "hi-z setting", outsHiZ, 1);
    modeSel = 3'b101; repeat (3) @(negedge clk);
    chk(outsHiZ && modeErr, "R8", "reserved 101 holds hi-z", {outsHiZ, modeErr}, 3);
    modeSel = 3'b010; repeat (2) @(negedge clk);
    chk(outsHiZ && modeErr, "R8", "reserved 010 holds hi-z", {outsHiZ, modeErr}, 3);
    modeSel = 3'b000; repeat (3) @(negedge clk);
    chk(!modeErr && !outsHiZ && !cpuFast, "R8", "valid code clears error", modeErr, 0);

    // R10: spread enable
    spreadN = 1'b0; repeat (3) @(negedge clk);
    chk(spreadEn == 6'b001111, "R10", "spread on", spreadEn, 6'b001111);
    spreadN = 1'b1; repeat (3) @(negedge clk);
    chk(spreadEn == 6'b0, "R10", "spread off", spreadEn, 0);

    // R3 / R4: shutdown
    pdN = 1'b0;
    waitOscLevel(1'b0, "R4");
    chk(outsQuiet, "R3", "quiet after shutdown", outsQuiet, 1);
    base = totalPulses;
    repeat (20) @(negedge clk);
    chk(totalPulses == base, "R3", "no pulses while down", totalPulses, base);

    // R9: test mode, switched while stopped
    modeSel = 3'b111; settle = 16'd3;
    repeat (3) @(negedge clk);
    pdN = 1'b1;
    takeSnap();
    repeat (80) @(negedge clk);
    checkRunning("R9");
    chk(testMode, "R9", "test mode flag", testMode, 1);
    modeSel = 3'b110; repeat (40) @(negedge clk);
    chk(modeErr && testMode, "R8", "reserved 110 keeps test mode", {modeErr, testMode}, 3);
    modeSel = 3'b111; repeat (2) @(negedge clk);

    // R12: power-down during a long settle
    pdN = 1'b0;
    waitOscLevel(1'b0, "R12");
    modeSel = 3'b000; settle = 16'd300;
    repeat (3) @(negedge clk);
    pdN = 1'b1;
    waitOscLevel(1'b1, "R12");
    repeat (30) @(negedge clk);
    base = totalPulses;
    pdN = 1'b0;
    waitOscLevel(1'b0, "R12");
    chk(totalPulses == base, "R12", "no pulse on aborted wake", totalPulses, base);
    chk(outsQuiet, "R12", "quiet after aborted wake", outsQuiet, 1);

    // R6: zero settle count
    settle = 16'd0;
    repeat (3) @(negedge clk);
    pdN = 1'b1;
    takeSnap();
    repeat (60) @(negedge clk);
    checkRunning("R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule